// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into its final page table entry. It reads up to two 32-bit words of a two-level page table through a plain word-read memory port. Pages are 8 KiB, so bits 12:0 of the virtual address are the page offset. Each level is indexed by 11 address bits. The first level uses the index VA[34:24]. Because a request carries only 32 bits, the top three bits of that index are always zero, and only VA[31:24] select a first-level entry. The second level uses VA[23:13].

Every entry carries two type bits. Bit 0 says the entry points to a next-level table. Bit 1 says the entry maps a page. The page number field of an entry starts at bit 13. The walker holds one translation at a time. It raises `busy` while the translation runs. It ends with a one-cycle `done` pulse that carries either the final entry, unchanged, or an invalid indication. The table base is a register written through the block's own port, and it always keeps its low 13 bits cleared.

Top module: `pt2_walker`

## Requirements
- R1: After reset `tbl_base` reads zero. A cycle with `base_wr` high loads `base_wdata` with bits 12:0 forced to zero, and `tbl_base` shows the new value from the next cycle on.
- R2: A request (`req_valid` high) is taken only while `busy` is low. `busy` is high from the cycle after acceptance until the result cycle. A request presented while `busy` is high is dropped: it causes no memory read and no result.
- R3: The first read address is `tbl_base` + VA[31:24]*4. The arithmetic is 32-bit.
- R4: If the first-level entry has bit 0 set, a second read is issued at {entry[31:13], 13'b0} + VA[23:13]*4. This happens whatever the value of bit 1.
- R5: If the first-level entry has bit 0 clear and bit 1 set, the walk ends with `done_ok` high and `done_pte` equal to that entry. No second read is made.
- R6: If the first-level entry has both bit 0 and bit 1 clear, the walk ends with `done_ok` low and `done_pte` zero.
- R7: A second-level entry with bit 1 set ends the walk with `done_ok` high and `done_pte` equal to the entry, bit for bit. With bit 1 clear the walk ends with `done_ok` low and `done_pte` zero, even when bit 0 is set.
- R8: `done` is high for exactly one cycle: the cycle after the clock edge at which the final response was taken. `busy` is low in that cycle, and a new request may be accepted in that same cycle.
- R9: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is high. A `mem_rsp_valid` that arrives while no read is outstanding is ignored.
- R10: When `base_wr` and an accepted request fall in the same cycle, that walk uses the base value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr | input | 1 | Write strobe for the table base |
| base_wdata | input | 32 | New table base; bits 12:0 are dropped |
| tbl_base | output | 32 | Current page-aligned table base |
| req_valid | input | 1 | Start a translation |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | A translation is in progress |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle result pulse |
| done_ok | output | 1 | Result is a valid leaf entry |
| done_pte | output | 32 | Leaf entry, or zero when invalid |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a write to the table base and the acceptance of a new translation. The bench drives both strobes on one falling edge, then checks that the first read address was built from the old base. It also checks that the new base reads back afterwards. The second pair is the result pulse of one walk and the acceptance of the next. The driver issues the next request in the very cycle `done` is seen. The scoreboard then checks that both results arrive in order and that the memory addresses match the queued expectations.

// File: rtl/pt2_walker.sv
module pt2_walker #(
  parameter int VA_W     = 32,
  parameter int PG_SHIFT = 13,
  parameter int IDX_W    = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_wr,
  input  logic [VA_W-1:0] base_wdata,
  output logic [VA_W-1:0] tbl_base,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  output logic            busy,
  output logic            mem_req_valid,
  output logic [VA_W-1:0] mem_req_addr,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_data,
  output logic            done,
  output logic            done_ok,
  output logic [VA_W-1:0] done_pte
);
  localparam int HI_W  = VA_W - PG_SHIFT - IDX_W;
  localparam int PAD_W = VA_W - IDX_W - 2;

  typedef enum logic [2:0] {S_IDLE, S_RQ1, S_WT1, S_RQ2, S_WT2} st_t;

  st_t             st;
  logic [VA_W-1:0] base_q, addr_q, pte_q;
  logic [IDX_W-1:0] va_lo_q;
  logic            done_q, ok_q;

  logic [IDX_W-1:0] idx1, idx2;
  logic [VA_W-1:0]  off1, off2, next_tbl;
  logic             take;

  assign idx1     = {{(IDX_W-HI_W){1'b0}}, req_va[VA_W-1 -: HI_W]};
  assign idx2     = va_lo_q;
  assign off1     = {{PAD_W{1'b0}}, idx1, 2'b00};
  assign off2     = {{PAD_W{1'b0}}, idx2, 2'b00};
  assign next_tbl = {mem_rsp_data[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign take     = (st == S_IDLE) && req_valid;

  assign tbl_base      = base_q;
  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_RQ1) || (st == S_RQ2);
  assign mem_req_addr  = addr_q;
  assign done          = done_q;
  assign done_ok       = ok_q;
  assign done_pte      = pte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_wr) begin
      base_q <= {base_wdata[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      va_lo_q <= '0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      pte_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          addr_q  <= base_q + off1;
          va_lo_q <= req_va[PG_SHIFT +: IDX_W];
          st      <= S_RQ1;
        end
        S_RQ1: if (mem_req_ready) st <= S_WT1;
        S_WT1: if (mem_rsp_valid) begin
          if (mem_rsp_data[0]) begin
            addr_q <= next_tbl + off2;
            st     <= S_RQ2;
          end else begin
            done_q <= 1'b1;
            ok_q   <= mem_rsp_data[1];
            pte_q  <= mem_rsp_data[1] ? mem_rsp_data : '0;
            st     <= S_IDLE;
          end
        end
        S_RQ2: if (mem_req_ready) st <= S_WT2;
        S_WT2: if (mem_rsp_valid) begin
          done_q <= 1'b1;
          ok_q   <= mem_rsp_data[1];
          pte_q  <= mem_rsp_data[1] ? mem_rsp_data : '0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> tbl_base[PG_SHIFT-1:0] == '0);
  a_r2_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_leaf_bit: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_ok |-> done_pte[1]);
  a_r6_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_ok |-> done_pte == '0);
endmodule

// File: tb/pt2_walker_bench.sv
module pt2_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic [31:0] tbl_base;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        busy;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, done_ok;
  logic [31:0] done_pte;

  pt2_walker u_pt2_walker (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .tbl_base(tbl_base), .req_valid(req_valid), .req_va(req_va), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_ok(done_ok), .done_pte(done_pte)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] memw [logic [31:0]];
  logic [31:0] addr_q [$];
  logic [32:0] res_q [$];
  logic [31:0] bmodel = '0;
  bit   stall_mode = 1'b0;
  int   lat = 1;
  bit   junk = 1'b0;
  int   cyc = 0;

  task automatic chk(input bit cond, input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memw.exists(a) ? memw[a] : 32'h0;
  endfunction

  // responder: address scoreboard and stall pattern
  initial begin
    int pend = 0;
    logic [31:0] pdata = '0;
    bit prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (junk) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 32'hFFFF_FFFF;
        junk = 1'b0;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pdata;
        end
      end
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R9 hold",
            {mem_req_valid, mem_req_addr}, {1'b1, prev_addr});
      mem_req_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (addr_q.size() == 0) begin
          chk(1'b0, "R2 unexpected read", {1'b0, mem_req_addr}, 33'h0);
        end else begin
          logic [31:0] ea;
          ea = addr_q.pop_front();
          chk(mem_req_addr == ea, "R3/R4 read address", {1'b0, mem_req_addr}, {1'b0, ea});
        end
        pdata = rd(mem_req_addr);
        pend  = lat;
      end
    end
  end

  // monitor: result scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        chk(!busy, "R8 busy low on done", {32'h0, busy}, 33'h0);
        if (res_q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", {done_ok, done_pte}, 33'h0);
        end else begin
          logic [32:0] e;
          e = res_q.pop_front();
          chk({done_ok, done_pte} == e, "R5/R6/R7 result", {done_ok, done_pte}, e);
        end
      end
    end
  end

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_wr = 1'b1; base_wdata = v;
    @(negedge clk);
    base_wr = 1'b0;
    bmodel = {v[31:13], 13'h0};
    chk(tbl_base == bmodel, "R1 base aligned", {1'b0, tbl_base}, {1'b0, bmodel});
  endtask

  // driver: predicts addresses and result, then issues one walk
  task automatic walk(input logic [31:0] va, input bit poke, input bit wr_base, input logic [31:0] nb);
    logic [31:0] a1, a2, e1, e2;
    a1 = bmodel + {22'h0, va[31:24], 2'b00};
    e1 = rd(a1);
    addr_q.push_back(a1);
    if (e1[0]) begin
      a2 = {e1[31:13], 13'h0} + {19'h0, va[23:13], 2'b00};
      e2 = rd(a2);
      addr_q.push_back(a2);
      res_q.push_back(e2[1] ? {1'b1, e2} : 33'h0);
    end else begin
      res_q.push_back(e1[1] ? {1'b1, e1} : 33'h0);
    end
    if (!done && busy) while (busy) @(negedge clk);
    req_valid = 1'b1; req_va = va;
    if (wr_base) begin base_wr = 1'b1; base_wdata = nb; end
    @(negedge clk);
    req_valid = 1'b0; base_wr = 1'b0;
    if (wr_base) bmodel = {nb[31:13], 13'h0};
    chk(busy, "R2 busy after accept", {32'h0, busy}, 33'h1);
    if (poke) begin
      req_valid = 1'b1; req_va = va ^ 32'h5500_0000;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    chk(addr_q.size() == 0 && res_q.size() == 0, "R2 scoreboard drained",
        {1'b0, 32'(addr_q.size())}, 33'h0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // tables
    memw[32'h0010_0000 + 32'h2AC] = 32'h0020_0001;           // VA top 0xAB -> table at 0x0020_0000
    memw[32'h0020_0000 + {19'h0, 11'h66F, 2'b00}] = 32'hABC0_23F2; // leaf
    memw[32'h0010_0000 + 32'h004] = 32'h0040_0002;           // VA top 0x01 -> level-1 leaf
    memw[32'h0010_0000 + 32'h008] = 32'h0000_0F0C;           // VA top 0x02 -> invalid
    memw[32'h0010_0000 + 32'h00C] = 32'h0030_0001;           // VA top 0x03 -> table at 0x0030_0000
    memw[32'h0030_0000 + 32'h010] = 32'h7777_6001;           // idx 4: non-leaf at level 2
    memw[32'h0010_0000 + 32'h010] = 32'h0060_0003;           // VA top 0x04 -> both bits, table wins
    memw[32'h0060_0000 + 32'h1FFC] = 32'h1234_E006;          // idx 0x7FF: leaf
    memw[32'h0050_0000 + 32'h014] = 32'h0BAD_0002;           // under other base, top 0x05

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tbl_base == 32'h0, "R1 reset base", {1'b0, tbl_base}, 33'h0);
    chk(!busy && !done && !mem_req_valid, "R2 reset idle",
        {30'h0, busy, done, mem_req_valid}, 33'h0);

    write_base(32'h0010_1FFF);                 // R1: low 13 bits dropped -> 0x0010_0000
    walk(32'hABCD_E123, 1'b0, 1'b0, '0);       // R3 R4 R7 two-level leaf
    settle();
    walk(32'h0100_2000, 1'b0, 1'b0, '0);       // R5 level-1 leaf
    walk(32'h0200_0000, 1'b0, 1'b0, '0);       // R6 invalid first level
    walk(32'h0300_8000, 1'b0, 1'b0, '0);       // R7 level-2 non-leaf
    walk(32'h04FF_E000, 1'b0, 1'b0, '0);       // R4 table bit wins, top index
    settle();                                   // R8 back-to-back walks above

    lat = 2; stall_mode = 1'b1;                 // R9 stalled request port
    walk(32'hABCD_E123, 1'b0, 1'b0, '0);
    walk(32'h0300_8000, 1'b0, 1'b0, '0);
    stall_mode = 1'b0; lat = 1;
    settle();

    walk(32'h0100_0000, 1'b1, 1'b0, '0);       // R2 request during busy dropped
    settle();

    @(negedge clk);
    junk = 1'b1;                                // R9 stray response while idle
    repeat (4) begin
      @(negedge clk);
      chk(!done && !busy, "R9 stray response ignored", {31'h0, done, busy}, 33'h0);
    end

    walk(32'h0100_0000, 1'b0, 1'b1, 32'h0050_0123); // R10 old base used for this walk
    settle();
    chk(tbl_base == 32'h0050_0000, "R10 new base after", {1'b0, tbl_base}, {1'b0, 32'h0050_0000});
    walk(32'h0500_0000, 1'b0, 1'b0, '0);       // R3 walk under new base
    settle();

    finish_run();
  end
endmodule